// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Programming Sequencer

This block writes a byte image into a one-time-programmable memory over a parallel interface. The interface carries an address, a write-data bus, a program-enable strobe, a read-enable strobe and a read-data bus. After a start request, the block latches an address window and raises a request for the high programming supply. It then visits every address in the window in ascending order. For each address it fetches the image byte from a synchronous source port and drives that byte with a setup interval. It applies one program pulse of fixed width, holds the data for a further interval, and reads the cell back. When the read-back differs from the image byte, the block retries with another pulse. It stops with a failure after a bounded number of failed verifies on the same byte.

When the last byte has verified, the block drops the supply request and waits a settle interval. It then reads the whole window once more at nominal supply and compares every byte with a fresh fetch from the source. It ends with a pass or fail verdict, and on a failure it records the address that failed. All interval lengths are counted in clock cycles and set by parameters, so the same block serves any clock frequency. The analog switching of the supply is outside the block; it only drives the request.

Top module: `otp_prog_seq`

## Requirements
- R1: After a synchronous active-low reset:
  - `busy`, `done`, `pass`, `fail`, `mem_pgm`, `mem_oe`, `supply_req` and `src_rd` are all low.
  - While `busy` is low, `mem_pgm`, `mem_oe` and `supply_req` stay low.
- R2: A `start` seen while idle latches `first_addr` and `last_addr` and raises `busy` and `supply_req` on the next cycle. A `start` seen while `busy` is high has no effect: the run goes on and no byte gets extra pulses.
- R3: Every program pulse meets these timing and supply rules:
  - `mem_pgm` is high for exactly T_PULSE consecutive cycles.
  - `supply_req` is high throughout the pulse.
  - `mem_addr` and `mem_wdata` are unchanged for at least T_SETUP cycles before the pulse and for the cycle after it.
- R4: Every pulse is followed by a verify read in which `mem_oe` is high for T_OE cycles. `mem_rdata` is compared with the image byte in the last of those cycles. `mem_pgm` and `mem_oe` are never high together.
- R5: A byte whose cell takes k pulses, with 1 <= k <= MAX_TRY, receives exactly k pulses. The block then moves to the next address, and the attempt count starts again at zero there.
- R6: When the verify of one byte fails for the MAX_TRY-th time, the run stops at once with these results:
  - `fail`=1, `pass`=0, `done`=1 and `busy`=0.
  - `fail_addr` holds that address and `supply_req` is low.
  - Later addresses receive no pulse.
- R7: After the last address verifies, `supply_req` goes low before the final compare. The compare reads every address of the window with `mem_oe` high for T_OE cycles each, at nominal supply and with no program pulse.
- R8: A mismatch in the final compare ends the run with `fail`=1 and `fail_addr` set to the first mismatching address.
- R9: When every byte matches in the final compare, the run ends with `pass`=1, `fail`=0 and `done`=1. After a passing run, every cell of the window holds its image byte. `pass` and `fail` are never high together.
- R10: `done`, `pass`, `fail` and `fail_addr` hold their values until the next accepted `start`, which clears `done`, `pass` and `fail`.
- R11: The block fetches each image byte by holding `src_rd` high for one cycle with `src_addr` set to the byte's address. It takes `src_data` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| first_addr | input | AW | Lowest address of the window |
| last_addr | input | AW | Highest address of the window |
| src_rd | output | 1 | Image fetch request |
| src_addr | output | AW | Image fetch address |
| src_data | input | DW | Image byte, valid the cycle after `src_rd` |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Data driven to the memory |
| mem_pgm | output | 1 | Program pulse strobe |
| mem_oe | output | 1 | Read-enable strobe |
| mem_rdata | input | DW | Data read from the memory |
| supply_req | output | 1 | Request for programming supply levels |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with a pass verdict |
| fail | output | 1 | Run finished with a fail verdict |
| fail_addr | output | AW | Address at which the failure was found |

## Verification
The bench builds the block with a 5-bit address and 8-bit data. The intervals are T_SETUP=3, T_PULSE=6, T_HOLD=2, T_OE=2 and T_SETTLE=4 cycles, and MAX_TRY is kept at 10. With these short intervals, one attempt takes about fifteen cycles. That makes a whole-array run over all 32 addresses, a byte that needs all ten attempts, a cell that never programs, and a cell that changes after the supply drops all cheap enough to run together with several random windows and random per-byte pulse needs. The small address width also puts address 0 and address 31 inside a full-array run.

// File: rtl/otp_seq_pkg.sv
// Package: shared state encoding of the programming sequencer.
// Assumes nothing beyond SystemVerilog 2017.
package otp_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,    // waiting for start
        ST_FETCH,   // request image byte for programming
        ST_LOAD,    // capture image byte
        ST_SETUP,   // data stable before pulse
        ST_PULSE,   // program strobe high
        ST_HOLD,    // data stable after pulse
        ST_VREAD,   // verify read
        ST_DROP,    // supply back to nominal, settle
        ST_CFETCH,  // request image byte for final compare
        ST_CLOAD,   // capture image byte for final compare
        ST_CREAD    // final compare read
    } seq_state_t;

endpackage

// File: rtl/otp_wait_timer.sv
// Module: down-counting interval timer.
// A load writes LEN-1; expired is high once the count reaches zero,
// so a state that loads on entry lasts LEN cycles.
// Assumes load values fit in TW bits.
module otp_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    // Count down toward zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/otp_attempt_ctr.sv
// Module: per-byte count of failed verify reads.
// at_limit flags that the next failed verify is the MAX_TRY-th one.
// Assumes MAX_TRY >= 1 and that clr and inc are never high together.
module otp_attempt_ctr #(
    parameter int MAX_TRY = 10,
    localparam int CW = $clog2(MAX_TRY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    logic [CW-1:0] cnt_q;

    // Track failed verifies of the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == CW'(MAX_TRY - 1));

endmodule

// File: rtl/otp_prog_seq.sv
// Module: programming sequencer for a one-time-programmable byte memory.
// Walks first..last: fetch, setup, pulse, hold, verify, retry up to MAX_TRY
// failed verifies; then drops supply request and compares the whole window.
// Assumes every T_* parameter >= 1 and first_addr <= last_addr at start.
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int AW       = 14,
    parameter int DW       = 8,
    parameter int T_SETUP  = 200,
    parameter int T_PULSE  = 100000,
    parameter int T_HOLD   = 200,
    parameter int T_OE     = 8,
    parameter int T_SETTLE = 200,
    parameter int MAX_TRY  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic          src_rd,
    output logic [AW-1:0] src_addr,
    input  logic [DW-1:0] src_data,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_pgm,
    output logic          mem_oe,
    input  logic [DW-1:0] mem_rdata,
    output logic          supply_req,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic [AW-1:0] fail_addr
);

    localparam int T_A   = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int T_B   = (T_HOLD > T_OE) ? T_HOLD : T_OE;
    localparam int T_C   = (T_A > T_B) ? T_A : T_B;
    localparam int T_MAX = (T_C > T_SETTLE) ? T_C : T_SETTLE;
    localparam int TW    = $clog2(T_MAX + 1);

    seq_state_t    state_q, state_d;
    logic [AW-1:0] addr_q, first_q, last_q, fail_addr_q;
    logic [DW-1:0] data_q;
    logic          supply_q, done_q, pass_q, fail_q;

    logic          tmr_exp, at_limit;
    logic [TW-1:0] tmr_val;
    logic          go, adv_addr, rewind, ld_data, att_clr, att_inc;
    logic          set_pass, set_fail, sup_off;
    logic          is_last, rd_match;

    assign is_last  = (addr_q == last_q);
    assign rd_match = (mem_rdata == data_q);

    // Next state and one-cycle control strobes.
    always_comb begin
        state_d  = state_q;
        go       = 1'b0;
        adv_addr = 1'b0;
        rewind   = 1'b0;
        ld_data  = 1'b0;
        att_clr  = 1'b0;
        att_inc  = 1'b0;
        set_pass = 1'b0;
        set_fail = 1'b0;
        sup_off  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    go      = 1'b1;
                    att_clr = 1'b1;
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: state_d = ST_LOAD;
            ST_LOAD: begin
                ld_data = 1'b1;
                state_d = ST_SETUP;
            end
            ST_SETUP: if (tmr_exp) state_d = ST_PULSE;
            ST_PULSE: if (tmr_exp) state_d = ST_HOLD;
            ST_HOLD:  if (tmr_exp) state_d = ST_VREAD;
            ST_VREAD: begin
                if (tmr_exp) begin
                    if (rd_match) begin
                        att_clr = 1'b1;
                        if (is_last) begin
                            sup_off = 1'b1;
                            state_d = ST_DROP;
                        end else begin
                            adv_addr = 1'b1;
                            state_d  = ST_FETCH;
                        end
                    end else if (at_limit) begin
                        set_fail = 1'b1;
                        sup_off  = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        att_inc = 1'b1;
                        state_d = ST_SETUP;
                    end
                end
            end
            ST_DROP: begin
                if (tmr_exp) begin
                    rewind  = 1'b1;
                    state_d = ST_CFETCH;
                end
            end
            ST_CFETCH: state_d = ST_CLOAD;
            ST_CLOAD: begin
                ld_data = 1'b1;
                state_d = ST_CREAD;
            end
            ST_CREAD: begin
                if (tmr_exp) begin
                    if (!rd_match) begin
                        set_fail = 1'b1;
                        state_d  = ST_IDLE;
                    end else if (is_last) begin
                        set_pass = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        adv_addr = 1'b1;
                        state_d  = ST_CFETCH;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Interval length of the state being entered.
    always_comb begin
        unique case (state_d)
            ST_SETUP:         tmr_val = TW'(T_SETUP - 1);
            ST_PULSE:         tmr_val = TW'(T_PULSE - 1);
            ST_HOLD:          tmr_val = TW'(T_HOLD - 1);
            ST_VREAD,
            ST_CREAD:         tmr_val = TW'(T_OE - 1);
            ST_DROP:          tmr_val = TW'(T_SETTLE - 1);
            default:          tmr_val = '0;
        endcase
    end

    otp_wait_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_d != state_q),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    otp_attempt_ctr #(.MAX_TRY(MAX_TRY)) u_att (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (att_clr),
        .inc      (att_inc),
        .at_limit (at_limit)
    );

    // State, address walk and data latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            first_q <= '0;
            last_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (go) begin
                addr_q  <= first_addr;
                first_q <= first_addr;
                last_q  <= last_addr;
            end else if (rewind) begin
                addr_q <= first_q;
            end else if (adv_addr) begin
                addr_q <= addr_q + 1'b1;
            end
            if (ld_data) data_q <= src_data;
        end
    end

    // Supply request and sticky verdict flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            supply_q    <= 1'b0;
            done_q      <= 1'b0;
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else if (go) begin
            supply_q <= 1'b1;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            if (sup_off) supply_q <= 1'b0;
            if (set_pass) begin
                done_q <= 1'b1;
                pass_q <= 1'b1;
            end
            if (set_fail) begin
                done_q      <= 1'b1;
                fail_q      <= 1'b1;
                fail_addr_q <= addr_q;
            end
        end
    end

    assign src_rd     = (state_q == ST_FETCH) || (state_q == ST_CFETCH);
    assign src_addr   = addr_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = data_q;
    assign mem_pgm    = (state_q == ST_PULSE);
    assign mem_oe     = (state_q == ST_VREAD) || (state_q == ST_CREAD);
    assign supply_req = supply_q;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign pass       = pass_q;
    assign fail       = fail_q;
    assign fail_addr  = fail_addr_q;

endmodule

// File: rtl/otp_prog_seq_chk.sv
// Module: property checker bound to the programming sequencer.
// Observes ports only; assumes the same T_PULSE as the design.
module otp_prog_seq_chk #(
    parameter int DW      = 8,
    parameter int T_PULSE = 100000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          mem_pgm,
    input logic          mem_oe,
    input logic [DW-1:0] mem_wdata,
    input logic          supply_req,
    input logic          pass,
    input logic          fail
);

    int unsigned pw_cnt;

    // Length of the current program pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pw_cnt <= 0;
        else        pw_cnt <= mem_pgm ? pw_cnt + 1 : 0;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_pgm && !mem_oe && !supply_req));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && supply_req));

    // R3
    pgm_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pgm |-> supply_req);

    // R3
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pgm |=> $stable(mem_wdata));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_pgm) |-> (pw_cnt == T_PULSE));

    // R4
    pgm_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_pgm && mem_oe));

    // R9
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

endmodule

bind otp_prog_seq otp_prog_seq_chk #(.DW(DW), .T_PULSE(T_PULSE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .mem_pgm    (mem_pgm),
    .mem_oe     (mem_oe),
    .mem_wdata  (mem_wdata),
    .supply_req (supply_req),
    .pass       (pass),
    .fail       (fail)
);

// File: tb/sim_otp_prog_seq.sv
// Bench: behavioural OTP cell model with per-byte pulse need (0 = never
// programs) and optional corruption of one cell when the supply drops.
module sim_otp_prog_seq;

    localparam int AW = 5, DW = 8, T_SETUP = 3, T_PULSE = 6, T_HOLD = 2;
    localparam int T_OE = 2, T_SETTLE = 4, MAX_TRY = 10, N = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] first_addr = '0, last_addr = '0;
    logic          src_rd, mem_pgm, mem_oe, supply_req, busy, done, pass, fail;
    logic [AW-1:0] src_addr, mem_addr, fail_addr;
    logic [DW-1:0] src_data = '0, mem_wdata, mem_rdata;

    otp_prog_seq #(.AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
        .T_HOLD(T_HOLD), .T_OE(T_OE), .T_SETTLE(T_SETTLE), .MAX_TRY(MAX_TRY)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
        .last_addr(last_addr), .src_rd(src_rd), .src_addr(src_addr),
        .src_data(src_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_pgm(mem_pgm), .mem_oe(mem_oe), .mem_rdata(mem_rdata),
        .supply_req(supply_req), .busy(busy), .done(done), .pass(pass),
        .fail(fail), .fail_addr(fail_addr));

    int checks = 0, errors = 0;

    function automatic logic [DW-1:0] img(input int a);
        return DW'((a * 29 + 7) | 1);
    endfunction

    // Image source: data valid the cycle after the request (R11).
    always @(posedge clk) if (src_rd) src_data <= img(int'(src_addr));

    logic [DW-1:0] arr [0:N-1];
    int            need [0:N-1];
    int            pulses [0:N-1];
    logic          clr_req = 1'b0, corrupt_en = 1'b0;
    int            corrupt_at = 0;
    logic          pgm_prev = 1'b0, sup_prev = 1'b0;
    logic [DW-1:0] wd_prev = '0;
    logic [AW-1:0] ad_prev = '0;
    int            pw = 0, st = 0, pw_bad = 0, setup_bad = 0, lo_pulse = 0, lo_oe = 0;

    assign mem_rdata = mem_oe ? arr[mem_addr] : '0;

    // Cell model and interface timing monitors.
    always @(posedge clk) begin
        if (clr_req) begin
            for (int i = 0; i < N; i++) begin
                arr[i]    <= '0;
                pulses[i] <= 0;
            end
            pw_bad <= 0; setup_bad <= 0; lo_pulse <= 0; lo_oe <= 0; pw <= 0;
        end else begin
            if (mem_pgm && !pgm_prev) begin
                if (st < T_SETUP) setup_bad <= setup_bad + 1;
                if (!supply_req) lo_pulse <= lo_pulse + 1;
                pulses[mem_addr] <= pulses[mem_addr] + 1;
                if (need[mem_addr] != 0 && pulses[mem_addr] + 1 == need[mem_addr])
                    arr[mem_addr] <= mem_wdata;
            end
            pw <= mem_pgm ? pw + 1 : 0;
            if (!mem_pgm && pgm_prev && pw != T_PULSE) pw_bad <= pw_bad + 1;
            if (mem_oe && !supply_req) lo_oe <= lo_oe + 1;
            if (corrupt_en && sup_prev && !supply_req)
                arr[corrupt_at] <= arr[corrupt_at] ^ 8'h40;
        end
        st       <= (mem_wdata != wd_prev || mem_addr != ad_prev) ? 1 : st + 1;
        pgm_prev <= mem_pgm;
        sup_prev <= supply_req;
        wd_prev  <= mem_wdata;
        ad_prev  <= mem_addr;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        @(negedge clk) clr_req = 1'b1;
        @(negedge clk) clr_req = 1'b0;
    endtask

    task automatic run(input int f, input int l, input bit mid_start);
        @(negedge clk);
        first_addr = AW'(f); last_addr = AW'(l); start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && supply_req && !done, "R2 busy+supply after start", busy, 1);
        if (mid_start) begin
            repeat (40) @(negedge clk);
            first_addr = AW'(l); start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        for (int n = 0; n < 40000 && !done; n++) @(negedge clk);
        chk(done && !busy, "R9 run finished", done, 1);
    endtask

    task automatic check_pass(input int f, input int l, input string tag);
        int bad_p = 0, bad_d = 0;
        for (int a = f; a <= l; a++) begin
            if (pulses[a] != need[a]) bad_p++;
            if (arr[a] != img(a)) bad_d++;
        end
        chk(pass && !fail, {tag, " R9 pass verdict"}, pass, 1);
        chk(bad_p == 0, {tag, " R5 pulses per byte"}, bad_p, 0);
        chk(bad_d == 0, {tag, " R9 R11 image written"}, bad_d, 0);
        chk(lo_oe == (l - f + 1) * T_OE, {tag, " R7 compare reads at nominal"}, lo_oe, (l - f + 1) * T_OE);
        chk(lo_pulse == 0 && !supply_req, {tag, " R7 no pulse at nominal"}, lo_pulse, 0);
        chk(pw_bad == 0, {tag, " R3 pulse width"}, pw_bad, 0);
        chk(setup_bad == 0, {tag, " R3 setup"}, setup_bad, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < N; i++) need[i] = 1;
        clr_req = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; clr_req = 1'b0;
        @(negedge clk);
        // R1
        chk(!busy && !done && !pass && !fail && !mem_pgm && !mem_oe && !supply_req && !src_rd,
            "R1 reset state", busy, 0);

        // Random pulse needs, extra start mid-run (R2, R5, R9)
        for (int i = 0; i < N; i++) need[i] = 1 + int'($urandom % 4);
        clear_model();
        run(2, 17, 1'b1);
        check_pass(2, 17, "rand");
        // R10 flags hold, then cleared by start
        repeat (6) @(negedge clk);
        chk(pass && done, "R10 verdict held", pass, 1);

        // Single byte needing exactly MAX_TRY pulses (R5 boundary)
        need[9] = MAX_TRY;
        clear_model();
        @(negedge clk);
        first_addr = 5'd9; last_addr = 5'd9; start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!pass && !done, "R10 start clears verdict", pass, 0);
        for (int n = 0; n < 40000 && !done; n++) @(negedge clk);
        check_pass(9, 9, "ten");

        // Cell never programs (R6)
        for (int i = 0; i < N; i++) need[i] = 2;
        need[5] = 0;
        clear_model();
        run(3, 8, 1'b0);
        chk(fail && !pass, "R6 fail verdict", fail, 1);
        chk(fail_addr == 5'd5, "R6 fail address", int'(fail_addr), 5);
        chk(pulses[5] == MAX_TRY, "R6 pulses before abort", pulses[5], MAX_TRY);
        chk(pulses[6] == 0, "R6 no later pulse", pulses[6], 0);
        chk(!supply_req && lo_oe == 0, "R6 supply dropped no compare", lo_oe, 0);

        // Cell flips after supply drops: compare mismatch (R8)
        for (int i = 0; i < N; i++) need[i] = 1;
        corrupt_at = 20; corrupt_en = 1'b1;
        clear_model();
        run(18, 23, 1'b0);
        corrupt_en = 1'b0;
        chk(fail && !pass, "R8 compare fail", fail, 1);
        chk(fail_addr == 5'd20, "R8 fail address", int'(fail_addr), 20);
        chk(pulses[23] == 1, "R7 programming completed before compare", pulses[23], 1);

        // Random windows
        for (int k = 0; k < 3; k++) begin
            int f, l;
            f = int'($urandom % 24);
            l = f + int'($urandom % 8);
            for (int i = 0; i < N; i++) need[i] = 1 + int'($urandom % MAX_TRY);
            clear_model();
            run(f, l, 1'b0);
            check_pass(f, l, "window");
        end

        // Whole array, address 0 and 31
        for (int i = 0; i < N; i++) need[i] = 1;
        clear_model();
        run(0, N - 1, 1'b0);
        check_pass(0, N - 1, "full");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

endmodule